// File: doc/BRIEF.md
# Fan Tachometer Period Meter

This block measures the time between edges on fan tachometer inputs. Up to `NCH` tach lines come into the block. Software starts a single measurement by first clearing a one-hot trigger word and then setting the bit of the channel it wants. The block then waits for one qualifying edge on that channel. It counts ticks of a divided tach clock until the next qualifying edge arrives. It then reports the count in one result word that all channels share.

Each channel names a settings slot through a 3-bit source field. The slot supplies the edge mode (falling, rising or both) and the tach clock divider code. Each channel also has an enable bit, and a disabled channel sees no edges.

In both-edge mode the count spans half a fan pulse period, so software doubles it to get the full period. The RPM arithmetic is done outside this block.

Top module: `fan_tach_meter`

## Requirements
- R1: The 2-bit edge mode of a slot is decoded as 2'b00 falling edges, 2'b01 rising edges, 2'b10 both edges and 2'b11 reserved. Only edges of the selected kind qualify.
- R2: Divider code d gives one tick every 4<<(2*d) clock cycles, measured from the first qualifying edge. If N cycles separate two qualifying edges at the pin, the reported value is floor((N-1)/(4<<(2*d))).
- R3: A measurement starts only in the cycle when `trigger` goes from all zeros to non-zero. If several bits are set, the lowest set bit picks the channel. Changing a non-zero word to another non-zero word starts nothing.
- R4: A start clears `result` to zero on the next clock edge.
- R5: `result` bit 31 is the done flag and bits CNT_W-1:0 hold the value. All other bits read zero.
- R6: If a second qualifying edge arrives while the count is still 0, it is ignored and counting goes on. Done is never reported with a value of 0.
- R7: If the count reaches all ones, done is set with the value all ones. This applies both while waiting for the first edge and while counting. The reserved mode 2'b11 has no qualifying edges, so it always ends this way.
- R8: A channel whose bit in `chan_en` is 0 has no qualifying edges, so its measurement ends by saturation.
- R9: The 3-bit field `chan_src[3n+2:3n]` selects which slot's mode (`slot_mode[2s+1:2s]`) and divider (`slot_div[2s+1:2s]`) channel n uses.
- R10: Once done is set, `result` holds its value until the next start, whatever the tach inputs do.
- R11: After reset, `result` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tach_in | input | NCH | Asynchronous tach lines, one per channel |
| chan_en | input | NCH | Per-channel enable |
| trigger | input | NCH | One-hot trigger word |
| chan_src | input | NCH*3 | Per-channel settings slot selector |
| slot_mode | input | NSRC*2 | Edge mode of each slot |
| slot_div | input | NSRC*DIV_W | Divider code of each slot |
| result | output | 32 | Done flag (bit 31) and measured value (low CNT_W bits) |

## Verification
Square waves with asymmetric high and low times are swept across every edge mode and two divider codes. The asymmetry makes falling, rising and both-edge counts differ, which separates the edge modes. Short waves with a high time under one tick make both-edge mode skip an edge that would give a count of zero. A very long low time makes the count saturate. The remaining tests use two channels that carry different waves: one picks between slots by source field, one checks priority between trigger bits, and one holds the result while the trigger is rewritten without first being cleared.

// File: rtl/fan_tach_pkg.sv
// Shared types of the fan tach meter.
// Assumes: the edge mode encoding is fixed by the software view.
package fan_tach_pkg;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_RSVD = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEEK,
        ST_COUNT,
        ST_DONE
    } meas_state_e;

endpackage

// File: rtl/tach_edge_sync.sv
// Two-flop synchroniser for one asynchronous tach line, followed by
// rising/falling edge detection on the synchronised level.
// Assumes: the line is slow compared to clk (at least a few cycles per level).
module tach_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic meta_q, sync_q, last_q;

    // Synchronise the pin and keep the previous synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    // Edge flags, valid for one cycle.
    always_comb begin
        rise = sync_q & ~last_q;
        fall = ~sync_q & last_q;
    end
endmodule

// File: rtl/tach_tick_div.sv
// Tach clock divider: produces one tick every 4 << (2*div_code) cycles.
// A restart zeroes the phase, and no tick is produced in the restart cycle.
// Assumes: DCNT_W is wide enough for the largest divisor minus one.
module tach_tick_div #(
    parameter int DIV_W  = 2,
    parameter int DCNT_W = 2 + 2 * ((1 << DIV_W) - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_code,
    output logic             tick
);
    logic [DCNT_W-1:0] phase_q;
    logic [DCNT_W:0]   last_phase;
    logic              at_end;

    // Last phase value before wrap for the current divider code.
    always_comb begin
        last_phase = ((DCNT_W + 1)'(4) << (2 * div_code)) - (DCNT_W + 1)'(1);
        at_end     = ({1'b0, phase_q} == last_phase);
        tick       = at_end & ~restart;
    end

    // Phase counter, wrapping at the divisor.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || at_end) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + DCNT_W'(1);
        end
    end
endmodule

// File: rtl/tach_period_ctrl.sv
// One-shot period measurement: after a start, waits for a qualifying edge,
// counts ticks until the next qualifying edge with a non-zero count, and
// latches the result. Saturation at all ones also ends the measurement.
// Assumes: qual and tick are single-cycle pulses.
module tach_period_ctrl
    import fan_tach_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             qual,
    input  logic             tick,
    output logic             restart,
    output logic             done,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    meas_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;

    // Divider phase restarts at a start and at the first qualifying edge.
    always_comb restart = start | ((state_q == ST_SEEK) & qual);

    // Measurement state, tick counter and latched result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            value   <= '0;
            done    <= 1'b0;
        end else if (start) begin
            state_q <= ST_SEEK;
            cnt_q   <= '0;
            value   <= '0;
            done    <= 1'b0;
        end else begin
            case (state_q)
                ST_SEEK: begin
                    if (qual) begin
                        state_q <= ST_COUNT;
                        cnt_q   <= '0;
                    end else if (tick) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (cnt_q == CNT_MAX - CNT_W'(1)) begin
                            state_q <= ST_DONE;
                            value   <= CNT_MAX;
                            done    <= 1'b1;
                        end
                    end
                end
                ST_COUNT: begin
                    if (qual && cnt_q != '0) begin
                        state_q <= ST_DONE;
                        value   <= cnt_q;
                        done    <= 1'b1;
                    end else if (tick) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (cnt_q == CNT_MAX - CNT_W'(1)) begin
                            state_q <= ST_DONE;
                            value   <= CNT_MAX;
                            done    <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fan_tach_meter.sv
// Top of the fan tach meter: trigger decode, channel selection, per-channel
// synchronisers, slot settings lookup, divider and measurement control.
// Assumes: NSRC slots are addressed by a 3-bit source field; CNT_W <= 31.
module fan_tach_meter
    import fan_tach_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int CNT_W = 20,
    parameter int NSRC  = 8,
    parameter int DIV_W = 2,
    localparam int SRC_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         tach_in,
    input  logic [NCH-1:0]         chan_en,
    input  logic [NCH-1:0]         trigger,
    input  logic [NCH*SRC_W-1:0]   chan_src,
    input  logic [NSRC*2-1:0]      slot_mode,
    input  logic [NSRC*DIV_W-1:0]  slot_div,
    output logic [31:0]            result
);
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int DCNT_W = 2 + 2 * ((1 << DIV_W) - 1);

    logic [NCH-1:0]   trig_prev;
    logic             start;
    logic [CH_W-1:0]  pick, chan_q;
    logic [NCH-1:0]   rise_v, fall_v;
    logic [SRC_W-1:0] src;
    edge_mode_e       mode;
    logic [DIV_W-1:0] div_code;
    logic             qual, tick, restart, done;
    logic [CNT_W-1:0] value;

    // Previous trigger word, sampled every cycle (reset-independent by intent).
    always_ff @(posedge clk) trig_prev <= trigger;

    // Start on zero-to-nonzero; lowest set bit picks the channel.
    always_comb begin
        start = (trig_prev == '0) && (trigger != '0);
        pick  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (trigger[i]) pick = CH_W'(i);
        end
    end

    // Latch the measured channel at each start.
    always_ff @(posedge clk) begin
        if (!rst_n)     chan_q <= '0;
        else if (start) chan_q <= pick;
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_sync
            tach_edge_sync u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .pin  (tach_in[g]),
                .rise (rise_v[g]),
                .fall (fall_v[g])
            );
        end
    endgenerate

    // Look up the slot settings and form the qualifying edge pulse.
    always_comb begin
        src      = chan_src[chan_q*SRC_W +: SRC_W];
        mode     = edge_mode_e'(slot_mode[src*2 +: 2]);
        div_code = slot_div[src*DIV_W +: DIV_W];
        case (mode)
            EDGE_FALL: qual = fall_v[chan_q];
            EDGE_RISE: qual = rise_v[chan_q];
            EDGE_BOTH: qual = rise_v[chan_q] | fall_v[chan_q];
            default:   qual = 1'b0;
        endcase
        qual = qual & chan_en[chan_q];
    end

    tach_tick_div #(.DIV_W(DIV_W), .DCNT_W(DCNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .div_code(div_code),
        .tick    (tick)
    );

    tach_period_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .qual   (qual),
        .tick   (tick),
        .restart(restart),
        .done   (done),
        .value  (value)
    );

    // Shared result word.
    always_comb result = {done, {(31 - CNT_W){1'b0}}, value};
endmodule

// File: rtl/fan_tach_checker.sv
// Port-level properties of the fan tach meter, bound to every instance.
// Assumes: trigger is driven synchronously to clk.
module fan_tach_checker #(
    parameter int NCH   = 16,
    parameter int CNT_W = 20
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] trigger,
    input logic [31:0]    result
);
    // R4
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(trigger) == '0 && trigger != '0) |=> (result == 32'h0));

    // R5
    spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result[30:CNT_W] == '0);

    // R6
    done_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result[31] |-> (result[CNT_W-1:0] != '0));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result[31] && !($past(trigger) == '0 && trigger != '0)) |=> $stable(result));
endmodule

bind fan_tach_meter fan_tach_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .trigger(trigger),
    .result (result)
);

// File: tb/sim_fan_tach_meter.sv
`timescale 1ns/1ps
module sim_fan_tach_meter;
    localparam int NCH   = 4;
    localparam int CNT_W = 10;
    localparam int NSRC  = 8;
    localparam int SRC_W = 3;
    localparam int DIV_W = 2;
    localparam int MAXV  = (1 << CNT_W) - 1;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NCH-1:0]        tach_in = '0;
    logic [NCH-1:0]        chan_en = '1;
    logic [NCH-1:0]        trigger = '0;
    logic [NCH*SRC_W-1:0]  chan_src = '0;
    logic [NSRC*2-1:0]     slot_mode = '0;
    logic [NSRC*DIV_W-1:0] slot_div = '0;
    logic [31:0]           result;
    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    fan_tach_meter #(.NCH(NCH), .CNT_W(CNT_W), .NSRC(NSRC), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .chan_en(chan_en),
        .trigger(trigger), .chan_src(chan_src), .slot_mode(slot_mode),
        .slot_div(slot_div), .result(result)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] done_word(int v);
        return 32'h8000_0000 | 32'(v);
    endfunction

    // Expected value from the edge list of a square wave (high h, low l).
    function automatic int exp_val(int mode, int lim, int h, int l);
        int e1 = -1;
        if (mode == 3) return MAXV;
        for (int i = 0; i < 400; i++) begin
            int  ev = (i / 2) * (h + l) + ((i % 2 == 1) ? h : 0);
            bit  is_rise = (i % 2 == 0);
            bit  q = (mode == 2) || (mode == 1 && is_rise) || (mode == 0 && !is_rise);
            if (q) begin
                if (e1 < 0) e1 = ev;
                else begin
                    int t = (ev - e1 - 1) / lim;
                    if (t >= MAXV) return MAXV;
                    if (t > 0) return t;
                end
            end
        end
        return MAXV;
    endfunction

    task automatic set_slot(int s, int mode, int dv);
        slot_mode[s*2 +: 2]         = 2'(mode);
        slot_div[s*DIV_W +: DIV_W]  = DIV_W'(dv);
    endtask

    task automatic set_src(int ch, int s);
        chan_src[ch*SRC_W +: SRC_W] = SRC_W'(s);
    endtask

    task automatic measure(logic [NCH-1:0] word, int ch, int h, int l,
                           int alt, int h2, int l2, output logic [31:0] res);
        int k = 0;
        int t0 = 2;
        @(negedge clk);
        tach_in = '0;
        trigger = '0;
        repeat (4) @(negedge clk);
        trigger = word;
        @(negedge clk);
        chk("R4 result cleared by start", result, 32'h0);
        while (k < 40000) begin
            tach_in[ch] = (k >= t0) && (((k - t0) % (h + l)) < h);
            if (alt >= 0) tach_in[alt] = (k >= t0) && (((k - t0) % (h2 + l2)) < h2);
            @(negedge clk);
            k++;
            if (result[31]) break;
        end
        res = result;
        tach_in = '0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r, held;
        int h_tab[5] = '{3, 5, 17, 40, 2};
        int l_tab[5] = '{2, 9, 23, 25, 5000};

        repeat (3) @(negedge clk);
        chk("R11 result during reset", result, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 result after reset", result, 32'h0);

        // R1 R2 R5 R6 R7: sweep of modes, dividers and waveforms on channel 0
        for (int m = 0; m < 3; m++) begin
            for (int dv = 0; dv < 2; dv++) begin
                for (int p = 0; p < 5; p++) begin
                    set_slot(0, m, dv);
                    measure(4'b0001, 0, h_tab[p], l_tab[p], -1, 1, 1, r);
                    chk($sformatf("R1 R2 R6 mode=%0d div=%0d h=%0d l=%0d", m, dv, h_tab[p], l_tab[p]),
                        r, done_word(exp_val(m, 4 << (2 * dv), h_tab[p], l_tab[p])));
                end
            end
        end

        // R7: reserved mode never qualifies
        set_slot(0, 3, 0);
        measure(4'b0001, 0, 10, 10, -1, 1, 1, r);
        chk("R7 reserved mode saturates", r, done_word(MAXV));

        // R8: disabled channel
        set_slot(0, 1, 0);
        chan_en[0] = 1'b0;
        measure(4'b0001, 0, 10, 10, -1, 1, 1, r);
        chk("R8 disabled channel saturates", r, done_word(MAXV));
        chan_en = '1;

        // R9: source field picks slot 5
        set_src(2, 5);
        set_slot(5, 2, 1);
        measure(4'b0100, 2, 20, 30, -1, 1, 1, r);
        chk("R9 slot5 both div1", r, done_word(exp_val(2, 16, 20, 30)));
        set_slot(5, 1, 0);
        measure(4'b0100, 2, 20, 30, -1, 1, 1, r);
        chk("R9 slot5 rise div0", r, done_word(exp_val(1, 4, 20, 30)));

        // R3: lowest set bit wins
        set_slot(5, 2, 1);
        set_src(1, 0);
        measure(4'b0110, 1, 10, 10, 2, 40, 40, r);
        chk("R3 lowest bit channel", r, done_word(exp_val(1, 4, 10, 10)));

        // R10: result held while inputs toggle
        held = result;
        for (int i = 0; i < 30; i++) begin
            tach_in[1] = 1'((i / 2) % 2);
            @(negedge clk);
        end
        chk("R10 result held", result, held);

        // R3: rewriting a nonzero word does not restart
        trigger = 4'b0010;
        for (int i = 0; i < 30; i++) begin
            tach_in[1] = 1'((i / 3) % 2);
            @(negedge clk);
        end
        chk("R3 no restart without clear", result, held);
        tach_in = '0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule